// File: doc/BRIEF.md
# Extended Tilemap Pixel Address Generator

This block turns a beam position into the video RAM reads that one tilemap playfield needs in the extended tile mode. When a request arrives, it adds the playfield's 0–15 pixel scroll offsets to the beam coordinates, reads the low and high bytes of the tile index from the split map area, and forms the byte address of the pixel inside the tile definition. The high index byte carries two flip controls. The block then reads that pixel byte and reports it, with a flag that marks the value zero as transparent for a later overlay stage.

Two tile geometries are supported: 16x16 tiles, with 11-bit indices and 256-byte definitions, and 8x8 tiles, with 13-bit indices and 64-byte definitions. A request also selects the playfield (A or B) and one of its two map buffers. An option swaps the lower and upper halves of the definition space. All three reads go through one synchronous read port that returns data one cycle after the address. Requests are serial: the block takes one request, finishes it, and then takes the next.

Top module: `ext_tile_addr_gen`

## Requirements
- R1: After reset, busy_o, mem_rd_o and done_o are 0.
- R2: A req_i seen while idle starts three reads on mem_rd_o. The reads are the index low byte, the index high byte and the pixel byte, in the 1st, 2nd and 4th cycles after the accepting edge. done_o is high for exactly one cycle, five clock edges after the accepting edge.
- R3: With 16x16 tiles (tile8_i=0), a map read goes to 0x70000 + {hi, pf, buf, row[3:0], col[4:0]}. Here hi is 0 for the low byte and 1 for the high byte, pf is 1 for playfield B, row is scrolled Y bits [7:4] and col is scrolled X bits [8:4]. The map row is 32 entries wide.
- R4: With 8x8 tiles (tile8_i=1), a map read goes to 0x70000 + {pf, buf, hi, row[4:0], col[5:0]}, with row equal to scrolled Y bits [7:3] and col equal to scrolled X bits [8:3]. The map row is 64 entries wide.
- R5: Scrolled X is (beam_x_i + scroll_x_i) mod 512 and scrolled Y is (beam_y_i + scroll_y_i) mod 256. The map row pointer therefore wraps to row 0.
- R6: With 16x16 tiles, the pixel address is {hi[2:0], lo, r[3:0], c[3:0]}, where r is scrolled Y[3:0] and c is scrolled X[3:0]. High-byte bits 5:3 have no effect.
- R7: With 8x8 tiles, the pixel address is {hi[4:0], lo, r[2:0], c[2:0]}. High-byte bit 5 has no effect.
- R8: High-byte bit 7 inverts the in-tile row r and bit 6 inverts the in-tile column c.
- R9: With def_swap_i=1, address bit 18 of the pixel read is inverted. Map reads are unaffected.
- R10: When done_o is high, pix_data_o holds the pixel byte that was read, pix_addr_o holds its address, and transparent_o is 1 exactly when that byte is zero.
- R11: A req_i that arrives while busy_o is 1 is ignored. The running transaction keeps its latched coordinates and settings, and no extra reads follow it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Start a lookup for the given beam position |
| beam_x_i | input | 9 | Beam X coordinate |
| beam_y_i | input | 8 | Beam Y coordinate |
| scroll_x_i | input | 4 | Horizontal scroll offset |
| scroll_y_i | input | 4 | Vertical scroll offset |
| tile8_i | input | 1 | 1: 8x8 tiles, 0: 16x16 tiles |
| buf_sel_i | input | 1 | Map buffer select |
| pf_sel_i | input | 1 | 0: playfield A, 1: playfield B |
| def_swap_i | input | 1 | Swap the definition halves |
| busy_o | output | 1 | Transaction in progress |
| mem_rd_o | output | 1 | Read strobe to video RAM |
| mem_addr_o | output | 19 | Read address |
| mem_data_i | input | 8 | Read data, one cycle after the strobe |
| done_o | output | 1 | One-cycle result strobe |
| pix_addr_o | output | 19 | Pixel byte address |
| pix_data_o | output | 8 | Pixel byte |
| transparent_o | output | 1 | Pixel byte is zero |

## Verification
An error in the scroll sum or the field packing shows up on mem_addr_o in the first read cycle after a request. A wrong captured index byte or a wrong flip shows up on the pixel read three cycles after the map reads. A fault in the sequencer moves done_o away from its fixed five-edge latency, or adds a read, or drops one. Each of these is therefore visible within six cycles of the request. The directed tests pick coordinates and index bytes whose fields differ bit by bit, so a swapped or shifted field changes the address.

// File: rtl/ext_tile_pkg.sv
package ext_tile_pkg;
  localparam int unsigned VRAM_AW = 19;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_LSB,
    ST_RD_MSB,
    ST_CALC,
    ST_RD_PIX,
    ST_WAIT
  } fetch_state_e;
endpackage

// File: rtl/ext_tile_map_addr.sv
module ext_tile_map_addr #(
  parameter int unsigned       AW       = 19,
  parameter int unsigned       XW       = 9,
  parameter int unsigned       YW       = 8,
  parameter logic [AW-1:0]     MAP_BASE = 19'h70000
) (
  input  logic [XW-1:3] col_i,
  input  logic [YW-1:3] row_i,
  input  logic          tile8_i,
  input  logic          buf_i,
  input  logic          pf_i,
  input  logic          hi_i,
  output logic [AW-1:0] addr_o
);
  localparam int unsigned OFF16_W = 3 + (YW - 4) + (XW - 4);
  localparam int unsigned OFF8_W  = 3 + (YW - 3) + (XW - 3);

  logic [OFF16_W-1:0] off16;
  logic [OFF8_W-1:0]  off8;

  // 16x16: byte-half outermost; 8x8: playfield outermost
  assign off16 = {hi_i, pf_i, buf_i, row_i[YW-1:4], col_i[XW-1:4]};
  assign off8  = {pf_i, buf_i, hi_i, row_i, col_i};

  always_comb begin
    if (tile8_i) addr_o = MAP_BASE + AW'(off8);
    else         addr_o = MAP_BASE + AW'(off16);
  end
endmodule

// File: rtl/ext_tile_pix_addr.sv
module ext_tile_pix_addr #(
  parameter int unsigned AW = 19
) (
  input  logic [7:0]    idx_lo_i,
  input  logic [4:0]    idx_hi_i,
  input  logic          hflip_i,
  input  logic          vflip_i,
  input  logic [3:0]    sub_x_i,
  input  logic [3:0]    sub_y_i,
  input  logic          tile8_i,
  input  logic          swap_i,
  output logic [AW-1:0] addr_o
);
  logic [3:0]    r, c;
  logic [AW-1:0] raw;

  assign r = sub_y_i ^ {4{vflip_i}};
  assign c = sub_x_i ^ {4{hflip_i}};

  always_comb begin
    if (tile8_i) raw = AW'({idx_hi_i, idx_lo_i, r[2:0], c[2:0]});
    else         raw = AW'({idx_hi_i[2:0], idx_lo_i, r, c});
    addr_o = raw ^ {swap_i, {(AW-1){1'b0}}};
  end
endmodule

// File: rtl/ext_tile_addr_gen.sv
module ext_tile_addr_gen
  import ext_tile_pkg::*;
#(
  parameter int unsigned   AW       = VRAM_AW,
  parameter int unsigned   XW       = 9,
  parameter int unsigned   YW       = 8,
  parameter int unsigned   SW       = 4,
  parameter logic [AW-1:0] MAP_BASE = 19'h70000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic [XW-1:0] beam_x_i,
  input  logic [YW-1:0] beam_y_i,
  input  logic [SW-1:0] scroll_x_i,
  input  logic [SW-1:0] scroll_y_i,
  input  logic          tile8_i,
  input  logic          buf_sel_i,
  input  logic          pf_sel_i,
  input  logic          def_swap_i,
  output logic          busy_o,
  output logic          mem_rd_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic [7:0]    mem_data_i,
  output logic          done_o,
  output logic [AW-1:0] pix_addr_o,
  output logic [7:0]    pix_data_o,
  output logic          transparent_o
);
  fetch_state_e state_q, state_d;

  logic [XW-1:0] sx_q;
  logic [YW-1:0] sy_q;
  logic          t8_q, buf_q, pf_q, swap_q;
  logic [7:0]    lsb_q;
  logic [AW-1:0] pix_addr_q, pix_addr_d, map_addr;
  logic [7:0]    pix_data_q;
  logic          done_q;
  logic          accept;

  assign accept = (state_q == ST_IDLE) && req_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (req_i) state_d = ST_RD_LSB;
      ST_RD_LSB: state_d = ST_RD_MSB;
      ST_RD_MSB: state_d = ST_CALC;
      ST_CALC:   state_d = ST_RD_PIX;
      ST_RD_PIX: state_d = ST_WAIT;
      ST_WAIT:   state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      sx_q       <= '0;
      sy_q       <= '0;
      t8_q       <= 1'b0;
      buf_q      <= 1'b0;
      pf_q       <= 1'b0;
      swap_q     <= 1'b0;
      lsb_q      <= '0;
      pix_addr_q <= '0;
      pix_data_q <= '0;
      done_q     <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= (state_q == ST_WAIT);
      if (accept) begin
        sx_q   <= beam_x_i + XW'(scroll_x_i);
        sy_q   <= beam_y_i + YW'(scroll_y_i);
        t8_q   <= tile8_i;
        buf_q  <= buf_sel_i;
        pf_q   <= pf_sel_i;
        swap_q <= def_swap_i;
      end
      if (state_q == ST_RD_MSB) lsb_q      <= mem_data_i;
      if (state_q == ST_CALC)   pix_addr_q <= pix_addr_d;
      if (state_q == ST_WAIT)   pix_data_q <= mem_data_i;
    end
  end

  ext_tile_map_addr #(
    .AW(AW), .XW(XW), .YW(YW), .MAP_BASE(MAP_BASE)
  ) u_map (
    .col_i  (sx_q[XW-1:3]),
    .row_i  (sy_q[YW-1:3]),
    .tile8_i(t8_q),
    .buf_i  (buf_q),
    .pf_i   (pf_q),
    .hi_i   (state_q == ST_RD_MSB),
    .addr_o (map_addr)
  );

  // high index byte arrives on mem_data_i during ST_CALC
  ext_tile_pix_addr #(.AW(AW)) u_pix (
    .idx_lo_i(lsb_q),
    .idx_hi_i(mem_data_i[4:0]),
    .hflip_i (mem_data_i[6]),
    .vflip_i (mem_data_i[7]),
    .sub_x_i (sx_q[3:0]),
    .sub_y_i (sy_q[3:0]),
    .tile8_i (t8_q),
    .swap_i  (swap_q),
    .addr_o  (pix_addr_d)
  );

  always_comb begin
    mem_rd_o   = 1'b0;
    mem_addr_o = '0;
    unique case (state_q)
      ST_RD_LSB, ST_RD_MSB: begin
        mem_rd_o   = 1'b1;
        mem_addr_o = map_addr;
      end
      ST_RD_PIX: begin
        mem_rd_o   = 1'b1;
        mem_addr_o = pix_addr_q;
      end
      default: ;
    endcase
  end

  assign busy_o        = (state_q != ST_IDLE);
  assign done_o        = done_q;
  assign pix_addr_o    = pix_addr_q;
  assign pix_data_o    = pix_data_q;
  assign transparent_o = (pix_data_q == 8'h00);

  assert_read_on_accept_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> mem_rd_o);

  assert_done_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_after_pix_read_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(mem_rd_o, 2) && !$past(mem_rd_o) && !mem_rd_o));

  assert_map_window_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_o && state_q != ST_RD_PIX) |-> (mem_addr_o[AW-1:14] == MAP_BASE[AW-1:14]));

  assert_cfg_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> ($stable(sx_q) && $stable(sy_q) && $stable(t8_q)
                                   && $stable(pf_q) && $stable(buf_q) && $stable(swap_q)));
endmodule

// File: tb/ext_tile_addr_gen_test.sv
module ext_tile_addr_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [8:0]  bx = '0;
  logic [7:0]  by = '0;
  logic [3:0]  scx = '0, scy = '0;
  logic        t8 = 1'b0, bsel = 1'b0, pf = 1'b0, swap = 1'b0;
  logic        busy, mem_rd, done, transp;
  logic [18:0] mem_addr, pix_addr;
  logic [7:0]  mem_data, pix_data;

  int total = 0, bad = 0;
  logic [7:0]  lsb_val, msb_val, pix_val;
  logic [18:0] rec [0:3];
  int          rd_idx;

  always #10 clk = ~clk;

  ext_tile_addr_gen uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req),
    .beam_x_i(bx), .beam_y_i(by), .scroll_x_i(scx), .scroll_y_i(scy),
    .tile8_i(t8), .buf_sel_i(bsel), .pf_sel_i(pf), .def_swap_i(swap),
    .busy_o(busy), .mem_rd_o(mem_rd), .mem_addr_o(mem_addr), .mem_data_i(mem_data),
    .done_o(done), .pix_addr_o(pix_addr), .pix_data_o(pix_data), .transparent_o(transp)
  );

  // memory model: answers by read order within a transaction
  always @(posedge clk) begin
    if (req && !busy) rd_idx <= 0;
    else if (mem_rd) begin
      if (rd_idx < 4) rec[rd_idx] <= mem_addr;
      mem_data <= (rd_idx == 0) ? lsb_val : (rd_idx == 1) ? msb_val : pix_val;
      rd_idx   <= rd_idx + 1;
    end
  end

  initial begin
    #4000000;
    total++; bad++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [18:0] emap(input logic [8:0] x, input logic [7:0] y,
      input logic [3:0] ox, input logic [3:0] oy, input logic m8, input logic b,
      input logic p, input logic hi);
    logic [8:0] sx; logic [7:0] sy;
    sx = x + 9'(ox); sy = y + 8'(oy);
    if (m8) return 19'h70000 + 19'({p, b, hi, sy[7:3], sx[8:3]});
    return 19'h70000 + 19'({hi, p, b, sy[7:4], sx[8:4]});
  endfunction

  function automatic logic [18:0] epix(input logic [8:0] x, input logic [7:0] y,
      input logic [3:0] ox, input logic [3:0] oy, input logic m8, input logic sw,
      input logic [7:0] lo, input logic [7:0] hi);
    logic [8:0] sx; logic [7:0] sy; logic [3:0] r, c; logic [18:0] a;
    sx = x + 9'(ox); sy = y + 8'(oy);
    r = sy[3:0]; c = sx[3:0];
    if (hi[7]) r = ~r;
    if (hi[6]) c = ~c;
    if (m8) a = {hi[4:0], lo, r[2:0], c[2:0]};
    else    a = {hi[2:0], lo, r, c};
    a[18] = a[18] ^ sw;
    return a;
  endfunction

  task automatic run(input string mtag, input string ptag,
      input logic [8:0] x, input logic [7:0] y, input logic [3:0] ox, input logic [3:0] oy,
      input logic m8, input logic b, input logic p, input logic sw,
      input logic [7:0] lo, input logic [7:0] hi, input logic [7:0] px,
      input logic busy_poke);
    int k;
    @(negedge clk);
    bx = x; by = y; scx = ox; scy = oy; t8 = m8; bsel = b; pf = p; swap = sw;
    lsb_val = lo; msb_val = hi; pix_val = px;
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    if (busy_poke) begin
      // R11: second request with other settings while busy
      bx = ~x; by = ~y; scx = ~ox; scy = ~oy; t8 = ~m8; bsel = ~b; pf = ~p; swap = ~sw;
      req = 1'b1;
    end
    k = 0;
    while (!done && k < 12) begin
      @(negedge clk);
      k++;
      if (k == 2) req = 1'b0;
    end
    req = 1'b0;
    chk("R2 latency", k, 5);
    chk({mtag, " lsb map addr"}, rec[0], emap(x, y, ox, oy, m8, b, p, 1'b0));
    chk({mtag, " msb map addr"}, rec[1], emap(x, y, ox, oy, m8, b, p, 1'b1));
    chk({ptag, " pixel read addr"}, rec[2], epix(x, y, ox, oy, m8, sw, lo, hi));
    chk("R10 pix_addr_o", pix_addr, epix(x, y, ox, oy, m8, sw, lo, hi));
    chk("R10 pix_data_o", pix_data, px);
    chk("R10 transparent_o", transp, (px == 8'h00));
    @(negedge clk);
    chk("R2 done one cycle", done, 0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(busy_poke ? "R11 no extra read" : "R2 no extra read", mem_rd, 0);
    end
  endtask

  task automatic t_reset;
    chk("R1 busy", busy, 0);
    chk("R1 mem_rd", mem_rd, 0);
    chk("R1 done", done, 0);
  endtask

  task automatic t_basic16;
    run("R3", "R6", 9'h0A7, 8'h5C, 4'h0, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA5, 8'h05, 8'h3C, 1'b0);
    run("R3", "R6", 9'h1F3, 8'hE1, 4'h0, 4'h0, 1'b0, 1'b1, 1'b1, 1'b0, 8'h5A, 8'h3A, 8'h81, 1'b0);
  endtask

  task automatic t_basic8;
    run("R4", "R7", 9'h0A7, 8'h5C, 4'h0, 4'h0, 1'b1, 1'b0, 1'b1, 1'b0, 8'hC3, 8'h35, 8'h11, 1'b0);
    run("R4", "R7", 9'h13D, 8'hA6, 4'h0, 4'h0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h0F, 8'h2A, 8'hFE, 1'b0);
  endtask

  task automatic t_scroll;
    run("R5", "R5", 9'h1FC, 8'hFA, 4'h8, 4'h9, 1'b0, 1'b0, 1'b1, 1'b0, 8'h12, 8'h01, 8'h40, 1'b0);
    run("R5", "R5", 9'h1FE, 8'hFB, 4'hF, 4'h7, 1'b1, 1'b1, 1'b0, 1'b0, 8'h34, 8'h12, 8'h40, 1'b0);
  endtask

  task automatic t_flip;
    run("R3", "R8", 9'h023, 8'h17, 4'h2, 4'h1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h77, 8'h82, 8'h09, 1'b0);
    run("R3", "R8", 9'h023, 8'h17, 4'h2, 4'h1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h77, 8'h42, 8'h09, 1'b0);
    run("R4", "R8", 9'h045, 8'h2B, 4'h0, 4'h3, 1'b1, 1'b0, 1'b0, 1'b0, 8'h99, 8'hC7, 8'h09, 1'b0);
  endtask

  task automatic t_swap;
    run("R9", "R9", 9'h100, 8'h80, 4'h5, 4'h6, 1'b0, 1'b1, 1'b0, 1'b1, 8'hF0, 8'h07, 8'h22, 1'b0);
    run("R9", "R9", 9'h100, 8'h80, 4'h5, 4'h6, 1'b1, 1'b0, 1'b1, 1'b1, 8'hF0, 8'h1F, 8'h22, 1'b0);
  endtask

  task automatic t_transparent;
    run("R3", "R10", 9'h011, 8'h22, 4'h0, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h01, 8'h00, 8'h00, 1'b0);
  endtask

  task automatic t_busy;
    run("R11", "R11", 9'h0B4, 8'h6D, 4'h3, 4'hC, 1'b0, 1'b1, 1'b0, 1'b0, 8'h6B, 8'h84, 8'h55, 1'b1);
  endtask

  initial begin
    mem_data = '0; lsb_val = '0; msb_val = '0; pix_val = '0; rd_idx = 0;
    for (int i = 0; i < 4; i++) rec[i] = '0;
    #1;
    t_reset();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_basic16();
    t_basic8();
    t_scroll();
    t_flip();
    t_swap();
    t_transparent();
    t_busy();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule